// File: doc/BRIEF.md
# Sliced Mantissa Shift-and-Add Accumulator

This block rebuilds wide dot products from narrow partial products. Each operand mantissa (up to 12 bits) is cut into equal slices whose width is chosen at run time between 3 and 6 bits. An external multiplier array multiplies slice pairs and returns each product as a magnitude with a sign flag and the two slice indices. The block moves each product to its place, a left shift by (index A + index B) times the slice width. It adds up to four such products per cycle and keeps a running two's-complement total across the whole dot product.

A dot product is framed by a start flag on its first beat and a last flag on its final beat. The start beat also carries the slice-width code and the two shared block exponents. One cycle after the last beat, the block presents the signed total and the exponent sum with a one-cycle valid pulse. Products of one element may be spread over several beats in any order, because every product lands in the same accumulator.

Control is a three-state machine. `S_IDLE` waits for a start. `S_ACCUM` adds beats. `S_EMIT` is the cycle in which the result is valid. The transitions are:

- start (`S_IDLE`→`S_ACCUM`)
- one-beat dot (`S_IDLE`/`S_ACCUM`/`S_EMIT`→`S_EMIT`, when start and last are on the same beat)
- close (`S_ACCUM`→`S_EMIT`)
- restart (`S_ACCUM`→`S_ACCUM` on a new start)
- back-to-back (`S_EMIT`→`S_ACCUM`)
- drain (`S_EMIT`→`S_IDLE`)

Top module: `sliced_mac_accum`

## Requirements
- R1: The slice-width code `cfg_wcode` is taken on the start beat. Codes 3 to 6 give that width, codes 0 to 2 act as 3, and code 7 acts as 6. The code on later beats of the same dot has no effect.
- R2: Lane k (k = 0..3) has a valid bit `lane_vld[k]`, a 12-bit magnitude `lane_mag[12k+11:12k]`, a sign `lane_neg[k]` (1 = negative) and 2-bit indices `lane_ia[2k+1:2k]` and `lane_ib[2k+1:2k]`. A valid lane adds ±magnitude << ((ia+ib)×width). A lane with its valid bit low adds nothing.
- R3: An accepted start beat discards any earlier partial total, and the start beat's own products count. A start that arrives in the middle of a dot abandons that dot without any output.
- R4: The result does not depend on how the slice products of the elements are ordered or grouped into beats.
- R5: After an accepted last beat, `out_valid` is high for exactly the next cycle, and `out_sum` equals the total including the last beat. `out_sum` changes only in cycles where `out_valid` is high.
- R6: `out_exp` is the 9-bit signed sum of the 8-bit signed `exp_a` and `exp_b` taken on the start beat. Exponent inputs on other beats are ignored.
- R7: Beats without a start flag that arrive outside a dot (while idle or just after a result) are ignored. They produce no output and do not change the next result.
- R8: `out_sum` is 35-bit two's complement. It is exact for 1024 elements of 4095×4095, whether all are positive or all are negative.
- R9: After reset, `out_valid`, `out_sum` and `out_exp` are zero.
- R10: A new dot may start in the cycle right after a last beat. Both results are delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat present |
| in_start | input | 1 | First beat of a dot product |
| in_last | input | 1 | Final beat of a dot product |
| cfg_wcode | input | 3 | Slice width code, taken on start beat |
| exp_a | input | 8 | Shared exponent of operand A block (signed) |
| exp_b | input | 8 | Shared exponent of operand B block (signed) |
| lane_vld | input | 4 | Per-lane product valid |
| lane_neg | input | 4 | Per-lane product sign |
| lane_mag | input | 48 | Four 12-bit product magnitudes |
| lane_ia | input | 8 | Four 2-bit slice indices of operand A |
| lane_ib | input | 8 | Four 2-bit slice indices of operand B |
| out_valid | output | 1 | Result pulse |
| out_sum | output | 35 | Signed accumulated mantissa result |
| out_exp | output | 9 | Signed exponent sum |

## Verification
Two situations are hard to reach from the ports.

The first is the accumulator's full range. It is only touched by a 1024-element dot in which every element is 4095×4095 with the same sign. The stimulus drives that dot twice, once positive and once negative, using 6-bit slices so that it fits in about a thousand beats.

The second is the abandoned dot. A dot is opened and fed products, and a new start then arrives with no last flag in between. The scoreboard expects only the second result. Every dot also drives random width codes and exponents on its non-start beats, and shuffles its slice products across lanes and beats. As a result, the capture rules (R1, R6) and order independence (R4) are exercised on every result.

// File: rtl/sma_pkg.sv
package sma_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ACCUM = 2'd1,
        S_EMIT  = 2'd2
    } sma_state_e;

endpackage

// File: rtl/sma_lane_align.sv
module sma_lane_align #(
    parameter int PROD_W  = 12,
    parameter int IDX_W   = 2,
    parameter int WCODE_W = 3,
    parameter int SH_W    = 6,
    parameter int ACC_W   = 35
) (
    input  logic               vld,
    input  logic               neg,
    input  logic [PROD_W-1:0]  mag,
    input  logic [IDX_W-1:0]   ia,
    input  logic [IDX_W-1:0]   ib,
    input  logic [WCODE_W-1:0] wdt,
    output logic [ACC_W-1:0]   term
);
    logic [IDX_W:0]   idx_sum;
    logic [SH_W-1:0]  shamt;
    logic [ACC_W-1:0] placed;

    always_comb begin
        idx_sum = {1'b0, ia} + {1'b0, ib};
        shamt   = SH_W'(idx_sum) * SH_W'(wdt);
        placed  = ACC_W'(mag) << shamt;
        if (!vld)
            term = '0;
        else if (neg)
            term = '0 - placed;
        else
            term = placed;
    end
endmodule

// File: rtl/sma_beat_sum.sv
module sma_beat_sum #(
    parameter int LANES = 4,
    parameter int ACC_W = 35
) (
    input  logic [LANES*ACC_W-1:0] terms,
    output logic [ACC_W-1:0]       total
);
    always_comb begin
        total = '0;
        for (int k = 0; k < LANES; k++) begin
            total = total + terms[k*ACC_W +: ACC_W];
        end
    end
endmodule

// File: rtl/sma_ctrl.sv
module sma_ctrl import sma_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_start,
    input  logic       in_last,
    output sma_state_e state,
    output logic       take,
    output logic       clear,
    output logic       fire
);
    sma_state_e state_nx;

    always_comb begin
        clear = in_valid && in_start;
        take  = clear || (in_valid && state == S_ACCUM);
        fire  = take && in_last;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (clear) state_nx = in_last ? S_EMIT : S_ACCUM;
            end
            S_ACCUM: begin
                if (fire) state_nx = S_EMIT;
            end
            S_EMIT: begin
                if (clear) state_nx = in_last ? S_EMIT : S_ACCUM;
                else       state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/sliced_mac_accum.sv
module sliced_mac_accum import sma_pkg::*; #(
    parameter int LANES    = 4,
    parameter int PROD_W   = 12,
    parameter int MANT_W   = 12,
    parameter int IDX_W    = 2,
    parameter int EXP_W    = 8,
    parameter int WCODE_W  = 3,
    parameter int W_MIN    = 3,
    parameter int W_MAX    = 6,
    parameter int MAX_LEN  = 1024,
    localparam int ACC_W   = 2*MANT_W + $clog2(MAX_LEN) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_start,
    input  logic                     in_last,
    input  logic [WCODE_W-1:0]       cfg_wcode,
    input  logic [EXP_W-1:0]         exp_a,
    input  logic [EXP_W-1:0]         exp_b,
    input  logic [LANES-1:0]         lane_vld,
    input  logic [LANES-1:0]         lane_neg,
    input  logic [LANES*PROD_W-1:0]  lane_mag,
    input  logic [LANES*IDX_W-1:0]   lane_ia,
    input  logic [LANES*IDX_W-1:0]   lane_ib,
    output logic                     out_valid,
    output logic [ACC_W-1:0]         out_sum,
    output logic [EXP_W:0]           out_exp
);
    localparam int MAX_IDX_SUM = 2 * ((1 << IDX_W) - 1);
    localparam int SH_W        = $clog2(MAX_IDX_SUM * W_MAX + 1);

    sma_state_e state;
    logic take, clear, fire;

    logic [WCODE_W-1:0] w_live, w_hold, w_use;
    logic [EXP_W:0]     e_live, e_hold, e_use;
    logic [LANES*ACC_W-1:0] terms;
    logic [ACC_W-1:0]   beat_total, acc, acc_nx;

    sma_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_start (in_start),
        .in_last  (in_last),
        .state    (state),
        .take     (take),
        .clear    (clear),
        .fire     (fire)
    );

    // width code clamp and start-beat capture
    always_comb begin
        if (cfg_wcode < WCODE_W'(W_MIN))      w_live = WCODE_W'(W_MIN);
        else if (cfg_wcode > WCODE_W'(W_MAX)) w_live = WCODE_W'(W_MAX);
        else                                  w_live = cfg_wcode;
        e_live = {exp_a[EXP_W-1], exp_a} + {exp_b[EXP_W-1], exp_b};
        w_use  = clear ? w_live : w_hold;
        e_use  = clear ? e_live : e_hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_hold <= WCODE_W'(W_MIN);
            e_hold <= '0;
        end else if (clear) begin
            w_hold <= w_live;
            e_hold <= e_live;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        sma_lane_align #(
            .PROD_W  (PROD_W),
            .IDX_W   (IDX_W),
            .WCODE_W (WCODE_W),
            .SH_W    (SH_W),
            .ACC_W   (ACC_W)
        ) u_align (
            .vld  (lane_vld[k]),
            .neg  (lane_neg[k]),
            .mag  (lane_mag[k*PROD_W +: PROD_W]),
            .ia   (lane_ia[k*IDX_W +: IDX_W]),
            .ib   (lane_ib[k*IDX_W +: IDX_W]),
            .wdt  (w_use),
            .term (terms[k*ACC_W +: ACC_W])
        );
    end

    sma_beat_sum #(
        .LANES (LANES),
        .ACC_W (ACC_W)
    ) u_sum (
        .terms (terms),
        .total (beat_total)
    );

    always_comb begin
        acc_nx = (clear ? '0 : acc) + beat_total;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    acc <= '0;
        else if (take) acc <= acc_nx;
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
            out_exp   <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_sum <= acc_nx;
                out_exp <= e_use;
            end
        end
    end
endmodule

// File: rtl/sma_chk.sv
module sma_chk import sma_pkg::*; #(
    parameter int ACC_W = 35
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_start,
    input logic             in_last,
    input sma_state_e       state,
    input logic             out_valid,
    input logic [ACC_W-1:0] out_sum
);
    // R5
    last_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last && (in_start || state == S_ACCUM)) |=> out_valid);

    // R5
    pulse_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (state == S_EMIT));

    // R5
    sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_sum));

    // R7
    stray_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && in_valid && !in_start) |=> !out_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !out_valid);
endmodule

bind sliced_mac_accum sma_chk #(.ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_start  (in_start),
    .in_last   (in_last),
    .state     (state),
    .out_valid (out_valid),
    .out_sum   (out_sum)
);

// File: tb/sliced_mac_accum_tb.sv
module sliced_mac_accum_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
    logic [2:0]  cfg_wcode = '0;
    logic [7:0]  exp_a = '0, exp_b = '0;
    logic [3:0]  lane_vld = '0, lane_neg = '0;
    logic [47:0] lane_mag = '0;
    logic [7:0]  lane_ia = '0, lane_ib = '0;
    logic        out_valid;
    logic [34:0] out_sum;
    logic [8:0]  out_exp;

    always #10 clk = ~clk;

    sliced_mac_accum u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .cfg_wcode(cfg_wcode), .exp_a(exp_a), .exp_b(exp_b),
        .lane_vld(lane_vld), .lane_neg(lane_neg), .lane_mag(lane_mag),
        .lane_ia(lane_ia), .lane_ib(lane_ib),
        .out_valid(out_valid), .out_sum(out_sum), .out_exp(out_exp)
    );

    typedef struct { int mag; bit neg; int ia; int ib; } prod_t;
    typedef struct { longint sum; int ex; string tag; } exp_t;

    exp_t  sb_q[$];
    prod_t pq[$];
    int    checks = 0, errors = 0, seen = 0, pushed = 0;
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string what, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            seen++;
            if (sb_q.size() == 0) begin
                chk(1'b0, "R7 unexpected result", $signed(out_sum), 0);
            end else begin
                exp_t e;
                longint got;
                e = sb_q.pop_front();
                got = $signed(out_sum);
                chk(got == e.sum, {e.tag, " sum"}, got, e.sum);
                chk(int'($signed(out_exp)) == e.ex, {"R6 ", e.tag, " exp"},
                    int'($signed(out_exp)), e.ex);
            end
        end
    end

    function automatic int eff_w(input int code);
        if (code < 3) return 3;
        if (code > 6) return 6;
        return code;
    endfunction

    task automatic idle(input int n);
        in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0; lane_vld = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_beats(input bit first_start, input bit close,
                               input int wcode, input int ea, input int eb, input bit sparse);
        bit first = first_start;
        while (pq.size() > 0) begin
            int k = sparse ? int'($urandom_range(1, 4)) : 4;
            int off = int'($urandom_range(0, 3));
            if (k > pq.size()) k = pq.size();
            lane_vld = '0; lane_neg = '0; lane_mag = '0; lane_ia = '0; lane_ib = '0;
            for (int l = 0; l < k; l++) begin
                prod_t p = pq.pop_front();
                int ln = (off + l) % 4;
                lane_vld[ln] = 1'b1;
                lane_neg[ln] = p.neg;
                lane_mag[ln*12 +: 12] = 12'(p.mag);
                lane_ia[ln*2 +: 2] = 2'(p.ia);
                lane_ib[ln*2 +: 2] = 2'(p.ib);
            end
            in_valid = 1'b1;
            in_start = first;
            in_last  = close && (pq.size() == 0);
            if (first) begin
                cfg_wcode = 3'(wcode); exp_a = 8'(ea); exp_b = 8'(eb);
            end else begin
                cfg_wcode = 3'($urandom_range(0, 7));
                exp_a = 8'($urandom); exp_b = 8'($urandom);
            end
            first = 1'b0;
            @(negedge clk);
        end
    endtask

    // mode: 0 random, 1 all max positive, 2 all max negative
    task automatic send_dot(input int n_el, input int wcode, input int mode,
                            input bit close, input bit sparse, input string tag);
        int w = eff_w(wcode);
        int ns = (12 + w - 1) / w;
        int ea = int'($urandom_range(0, 255)) - 128;
        int eb = int'($urandom_range(0, 255)) - 128;
        longint total = 0;
        exp_t e;
        pq.delete();
        for (int el = 0; el < n_el; el++) begin
            int a, b;
            bit ng;
            if (mode == 0) begin
                a = int'($urandom_range(0, 4095)); b = int'($urandom_range(0, 4095));
                ng = 1'($urandom);
            end else begin
                a = 4095; b = 4095; ng = (mode == 2);
            end
            total += ng ? -(longint'(a) * b) : longint'(a) * b;
            for (int i = 0; i < ns; i++)
                for (int j = 0; j < ns; j++) begin
                    prod_t p;
                    p.mag = ((a >> (i*w)) & ((1 << w) - 1)) * ((b >> (j*w)) & ((1 << w) - 1));
                    p.neg = ng; p.ia = i; p.ib = j;
                    pq.push_back(p);
                end
        end
        for (int k = pq.size() - 1; k > 0; k--) begin
            int r = int'($urandom_range(0, k));
            prod_t t = pq[k];
            pq[k] = pq[r];
            pq[r] = t;
        end
        if (close) begin
            e.sum = total; e.ex = ea + eb; e.tag = tag;
            sb_q.push_back(e);
            pushed++;
        end
        drive_beats(1'b1, close, wcode, ea, eb, sparse);
    endtask

    // beats with no start outside a dot
    task automatic stray(input int n);
        pq.delete();
        for (int k = 0; k < 4 * n; k++) begin
            prod_t p;
            p.mag = int'($urandom_range(1, 4095)); p.neg = 1'($urandom);
            p.ia = int'($urandom_range(0, 3)); p.ib = int'($urandom_range(0, 3));
            pq.push_back(p);
        end
        drive_beats(1'b0, 1'b1, 5, 0, 0, 1'b0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(out_valid == 1'b0, "R9 out_valid at reset", out_valid, 0);
        chk(out_sum == '0, "R9 out_sum at reset", out_sum, 0);
        chk(out_exp == '0, "R9 out_exp at reset", out_exp, 0);
        rst_n = 1'b1;
        idle(2);

        // R1 R2 R4: each legal width, dense and sparse lanes
        send_dot(8, 3, 0, 1, 0, "R1 R2 R4 w3"); idle(2);
        send_dot(8, 4, 0, 1, 1, "R1 R2 R4 w4 sparse"); idle(2);
        send_dot(8, 5, 0, 1, 0, "R1 R2 R4 w5"); idle(2);
        send_dot(8, 6, 0, 1, 1, "R1 R2 R4 w6 sparse"); idle(2);
        // R1 clamped codes
        send_dot(5, 0, 0, 1, 0, "R1 code0 as w3"); idle(1);
        send_dot(5, 7, 0, 1, 1, "R1 code7 as w6"); idle(1);
        // one-beat dot: start and last together
        send_dot(1, 6, 0, 1, 0, "R5 single beat"); idle(3);
        // R7 stray beats, then a dot that must be unaffected
        stray(3); idle(2);
        send_dot(4, 4, 0, 1, 0, "R7 after stray"); idle(1);
        // R10 back-to-back, then stray beats right after a result
        send_dot(6, 5, 0, 1, 1, "R10 first");
        send_dot(6, 3, 0, 1, 0, "R10 second");
        stray(2); idle(2);
        // R3 restart in the middle of a dot
        send_dot(6, 4, 0, 0, 0, "abandoned");
        send_dot(6, 4, 0, 1, 1, "R3 restart"); idle(2);
        // R8 full range both signs
        send_dot(1024, 6, 1, 1, 0, "R8 max positive"); idle(2);
        send_dot(1024, 6, 2, 1, 0, "R8 max negative"); idle(2);
        // R4 longer random dot with narrow slices
        send_dot(64, 3, 0, 1, 1, "R4 long w3"); idle(4);

        chk(sb_q.size() == 0, "R5 results missing", sb_q.size(), 0);
        chk(seen == pushed, "R5 result count", seen, pushed);
        finish_run();
    end
endmodule